// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences a small processor subsystem into and out of three low-power modes. Software writes a 2-bit mode field, a 32-bit mask that picks which GPIO lines may wake the device, and a qualification length. It then raises an idle-request pulse. The controller enters the selected mode and drives three enables: the oscillator, the core clock and the system clock output. It leaves the mode when one of the sources that mode permits goes low.

The wake sources are the watchdog interrupt, an enabled-interrupt indication, the non-maskable interrupt, a debugger request and the masked GPIO lines. All of them are active low, and each mode accepts its own subset. In the mode that keeps the oscillator alive, a GPIO wake must stay low for a programmable number of consecutive oscillator cycles. A shorter pulse is dropped and the device stays asleep. In the deepest mode the oscillator is off, so GPIO lines are not qualified. Any wake from that mode first restarts the oscillator and counts a fixed stabilisation period before the core clock returns. The block runs on an always-on reference clock. Reset is asynchronous and active low, and always returns the block to the running state.

Top module: `lpm_top`

## Requirements
- R1: After reset the block is running: all three enables are 1, `inLowPower` is 0, `lpMode` is 00, `wakePulse` is 0. The mode field and the wake mask are cleared. With the cleared mask no GPIO line can wake the device.
- R2: Mode field 00 selects the light mode: `lpMode` = 00, `inLowPower` = 1, all three enables stay 1.
- R3: Mode field 01 selects the middle mode: `lpMode` = 01, the oscillator enable is 1, and the core and system-output enables are 0.
- R4: Mode field 10 selects the deep mode: `lpMode` = 10, and all three enables are 0.
- R5: Mode field 11 also selects the deep mode, so `lpMode` reads 10.
- R6: The light mode is left one clock edge after the watchdog, the enabled-interrupt or the non-maskable input is sampled low. The debugger request and GPIO lines are ignored in this mode.
- R7: The middle mode is left one edge after the watchdog, the debugger or the non-maskable input is sampled low, or after a qualified GPIO wake. The enabled-interrupt input is ignored in this mode.
- R8: In the deep mode, the watchdog and enabled-interrupt inputs are ignored. A low non-maskable input, debugger request or selected GPIO line is accepted on one sample. Acceptance raises the oscillator enable at once and holds the core enable at 0 for 16 edges. The block is running again on the 17th edge after the wake was sampled.
- R9: A GPIO line counts as a wake only when its mask bit is 1, with bit i of the mask matching line i.
- R10: In the middle mode, a selected GPIO wake is taken on the N-th consecutive edge at which it is sampled low, where N is the window. A low run shorter than N leaves the block asleep.
- R11: The window is the 6-bit qualification input plus one, with a floor of 2, giving a range of 2 to 64.
- R12: `wakePulse` is 1 for exactly one cycle: the first running cycle after any low-power mode.
- R13: Configuration writes take effect only while the block is running. A write while asleep leaves the mode field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write strobe |
| cfgModeIn | input | 2 | Mode field value to write |
| cfgMaskIn | input | 32 | GPIO wake mask to write |
| cfgQualIn | input | 6 | Qualification length code (window = value + 1, floor 2) |
| idleReq | input | 1 | Request to enter the configured mode |
| wdIntN | input | 1 | Watchdog interrupt, active low |
| nmiN | input | 1 | Non-maskable interrupt, active low |
| intPendN | input | 1 | Enabled interrupt pending, active low |
| dbgReqN | input | 1 | Debugger request, active low |
| gpioIn | input | 32 | GPIO port lines, low means wake |
| oscEn | output | 1 | Oscillator enable |
| cpuClkEn | output | 1 | Core clock enable |
| sysClkOutEn | output | 1 | System clock output enable |
| inLowPower | output | 1 | 1 while in any low-power mode or stabilisation |
| lpMode | output | 2 | Current mode: 00 light or running, 01 middle, 10 deep |
| wakePulse | output | 1 | One-cycle pulse on return to running |

## Verification
Inputs are driven on the falling edge, and outputs are sampled on the next falling edge. An idle request or a light- or middle-mode wake is therefore seen after exactly one rising edge. A qualified GPIO wake is seen after N edges, and a deep-mode wake after 17 edges, with `wakePulse` high in that same sample and low in the next. The corner-case checks sample one edge before and one edge at each boundary, which catches an off-by-one in the qualifier and in the stabilisation counter.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_LIGHT,
    ST_MID,
    ST_DEEP,
    ST_WARM
  } lpmState_e;

  typedef struct packed {
    logic cfgAccept;
    logic qualRun;
  } lpmStrb_t;

  localparam logic [1:0] MODE_LIGHT = 2'b00;
  localparam logic [1:0] MODE_MID   = 2'b01;
  localparam logic [1:0] MODE_DEEP  = 2'b10;
endpackage

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int GPIO_W = 32,
  parameter int QUAL_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  lpmStrb_t          strb,
  input  logic              cfgWe,
  input  logic [1:0]        cfgModeIn,
  input  logic [GPIO_W-1:0] cfgMaskIn,
  input  logic [QUAL_W-1:0] cfgQualIn,
  input  logic [GPIO_W-1:0] gpioIn,
  output logic [1:0]        modeField,
  output logic              gpioSelLow,
  output logic              gpioQualOk
);
  localparam int CNT_W = QUAL_W + 1;
  localparam logic [CNT_W-1:0] MIN_WIN = CNT_W'(2);

  logic [1:0]        modeReg;
  logic [GPIO_W-1:0] maskReg;
  logic [CNT_W-1:0]  qualWin;
  logic [CNT_W-1:0]  qualCnt;
  logic [CNT_W-1:0]  winRaw;
  logic [CNT_W-1:0]  winNext;

  // window = code + 1, never below two cycles
  always_comb begin
    winRaw  = {1'b0, cfgQualIn} + CNT_W'(1);
    winNext = (winRaw < MIN_WIN) ? MIN_WIN : winRaw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= MODE_LIGHT;
      maskReg <= '0;
      qualWin <= MIN_WIN;
    end else if (strb.cfgAccept && cfgWe) begin
      modeReg <= cfgModeIn;
      maskReg <= cfgMaskIn;
      qualWin <= winNext;
    end
  end

  // consecutive-low counter, cleared on any high sample or outside the mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualCnt <= '0;
    end else if (!strb.qualRun || !gpioSelLow) begin
      qualCnt <= '0;
    end else if (qualCnt != '1) begin
      qualCnt <= qualCnt + CNT_W'(1);
    end
  end

  assign modeField  = modeReg;
  assign gpioSelLow = |(~gpioIn & maskReg);
  assign gpioQualOk = strb.qualRun && gpioSelLow && (qualCnt >= qualWin - CNT_W'(1));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int WARM_CYC = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       idleReq,
  input  logic       wdIntN,
  input  logic       nmiN,
  input  logic       intPendN,
  input  logic       dbgReqN,
  input  logic [1:0] modeField,
  input  logic       gpioSelLow,
  input  logic       gpioQualOk,
  output lpmStrb_t   strb,
  output logic       oscEn,
  output logic       cpuClkEn,
  output logic       sysClkOutEn,
  output logic       inLowPower,
  output logic [1:0] lpMode,
  output logic       wakePulse
);
  localparam int WC_W = (WARM_CYC > 2) ? $clog2(WARM_CYC) : 1;
  localparam logic [WC_W-1:0] WARM_LOAD = WC_W'(WARM_CYC - 1);

  lpmState_e state, nxt;
  logic [WC_W-1:0] warmCnt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN: if (idleReq) begin
        if (modeField[1])      nxt = ST_DEEP;
        else if (modeField[0]) nxt = ST_MID;
        else                   nxt = ST_LIGHT;
      end
      ST_LIGHT: if (!wdIntN || !intPendN || !nmiN) nxt = ST_RUN;
      ST_MID:   if (!wdIntN || !nmiN || !dbgReqN || gpioQualOk) nxt = ST_RUN;
      ST_DEEP:  if (!nmiN || !dbgReqN || gpioSelLow) nxt = ST_WARM;
      ST_WARM:  if (warmCnt == '0) nxt = ST_RUN;
      default:  nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RUN;
      wakePulse <= 1'b0;
      warmCnt   <= '0;
    end else begin
      state     <= nxt;
      wakePulse <= (state != ST_RUN) && (nxt == ST_RUN);
      if (state == ST_DEEP)                     warmCnt <= WARM_LOAD;
      else if (state == ST_WARM && warmCnt != '0) warmCnt <= warmCnt - WC_W'(1);
    end
  end

  always_comb begin
    oscEn       = 1'b1;
    cpuClkEn    = 1'b1;
    sysClkOutEn = 1'b1;
    lpMode      = MODE_LIGHT;
    unique case (state)
      ST_MID: begin
        cpuClkEn = 1'b0; sysClkOutEn = 1'b0; lpMode = MODE_MID;
      end
      ST_DEEP: begin
        oscEn = 1'b0; cpuClkEn = 1'b0; sysClkOutEn = 1'b0; lpMode = MODE_DEEP;
      end
      ST_WARM: begin
        cpuClkEn = 1'b0; sysClkOutEn = 1'b0; lpMode = MODE_DEEP;
      end
      default: ;
    endcase
  end

  assign inLowPower     = (state != ST_RUN);
  assign strb.cfgAccept = (state == ST_RUN);
  assign strb.qualRun   = (state == ST_MID);
endmodule

// File: rtl/lpm_top.sv
module lpm_top
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [1:0]  cfgModeIn,
  input  logic [31:0] cfgMaskIn,
  input  logic [5:0]  cfgQualIn,
  input  logic        idleReq,
  input  logic        wdIntN,
  input  logic        nmiN,
  input  logic        intPendN,
  input  logic        dbgReqN,
  input  logic [31:0] gpioIn,
  output logic        oscEn,
  output logic        cpuClkEn,
  output logic        sysClkOutEn,
  output logic        inLowPower,
  output logic [1:0]  lpMode,
  output logic        wakePulse
);
  lpmStrb_t   strb;
  logic [1:0] modeField;
  logic       gpioSelLow;
  logic       gpioQualOk;

  lpm_datapath #(.GPIO_W(32), .QUAL_W(6)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWe(cfgWe),
    .cfgModeIn(cfgModeIn), .cfgMaskIn(cfgMaskIn), .cfgQualIn(cfgQualIn),
    .gpioIn(gpioIn), .modeField(modeField), .gpioSelLow(gpioSelLow),
    .gpioQualOk(gpioQualOk)
  );

  lpm_ctrl #(.WARM_CYC(16)) u_ctrl (
    .clk(clk), .rstN(rstN), .idleReq(idleReq), .wdIntN(wdIntN), .nmiN(nmiN),
    .intPendN(intPendN), .dbgReqN(dbgReqN), .modeField(modeField),
    .gpioSelLow(gpioSelLow), .gpioQualOk(gpioQualOk), .strb(strb),
    .oscEn(oscEn), .cpuClkEn(cpuClkEn), .sysClkOutEn(sysClkOutEn),
    .inLowPower(inLowPower), .lpMode(lpMode), .wakePulse(wakePulse)
  );
endmodule

// File: rtl/lpm_checker.sv
module lpm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wdIntN,
  input logic       nmiN,
  input logic       dbgReqN,
  input logic       gpioSelLow,
  input logic [1:0] modeField,
  input logic       oscEn,
  input logic       cpuClkEn,
  input logic       sysClkOutEn,
  input logic       inLowPower,
  input logic [1:0] lpMode,
  input logic       wakePulse
);
  p_light_clocks_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inLowPower && lpMode == 2'b00) |-> (oscEn && cpuClkEn && sysClkOutEn));

  p_mid_clocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inLowPower && lpMode == 2'b01) |-> (oscEn && !cpuClkEn && !sysClkOutEn));

  p_deep_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inLowPower && lpMode == 2'b10) |-> (!cpuClkEn && !sysClkOutEn));

  // watchdog alone never restarts the oscillator
  p_deep_no_wd_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inLowPower && lpMode == 2'b10 && !oscEn && nmiN && dbgReqN && !gpioSelLow) |=> !oscEn);

  // core clock only returns with the oscillator already up
  p_osc_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuClkEn) |-> $past(oscEn));

  p_wake_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (!inLowPower && $past(inLowPower)));

  p_wake_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  p_cfg_locked_r13: assert property (@(posedge clk) disable iff (!rstN)
    inLowPower |=> $stable(modeField));
endmodule

bind lpm_top lpm_checker u_chk (
  .clk(clk), .rstN(rstN), .wdIntN(wdIntN), .nmiN(nmiN), .dbgReqN(dbgReqN),
  .gpioSelLow(gpioSelLow), .modeField(modeField), .oscEn(oscEn),
  .cpuClkEn(cpuClkEn), .sysClkOutEn(sysClkOutEn), .inLowPower(inLowPower),
  .lpMode(lpMode), .wakePulse(wakePulse)
);

// File: tb/sim_lpm_top.sv
module sim_lpm_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWe;
  logic [1:0]  cfgModeIn;
  logic [31:0] cfgMaskIn;
  logic [5:0]  cfgQualIn;
  logic        idleReq, wdIntN, nmiN, intPendN, dbgReqN;
  logic [31:0] gpioIn;
  logic        oscEn, cpuClkEn, sysClkOutEn, inLowPower, wakePulse;
  logic [1:0]  lpMode;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [31:0] curMask = '0;
  logic [5:0]  curQual = '0;

  always #2.5 clk = ~clk;

  lpm_top u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgModeIn(cfgModeIn),
    .cfgMaskIn(cfgMaskIn), .cfgQualIn(cfgQualIn), .idleReq(idleReq),
    .wdIntN(wdIntN), .nmiN(nmiN), .intPendN(intPendN), .dbgReqN(dbgReqN),
    .gpioIn(gpioIn), .oscEn(oscEn), .cpuClkEn(cpuClkEn),
    .sysClkOutEn(sysClkOutEn), .inLowPower(inLowPower), .lpMode(lpMode),
    .wakePulse(wakePulse)
  );

  // row: [7:6] mode, [5:4] source (0 wd, 1 int, 2 nmi, 3 dbg),
  //      [3] expected inLowPower, [2] oscEn, [1] cpuClkEn after one edge
  localparam logic [7:0] VEC [12] = '{
    {2'b00, 2'd0, 3'b011, 1'b0}, {2'b00, 2'd1, 3'b011, 1'b0},
    {2'b00, 2'd2, 3'b011, 1'b0}, {2'b00, 2'd3, 3'b111, 1'b0},
    {2'b01, 2'd0, 3'b011, 1'b0}, {2'b01, 2'd1, 3'b110, 1'b0},
    {2'b01, 2'd3, 3'b011, 1'b0}, {2'b01, 2'd2, 3'b011, 1'b0},
    {2'b10, 2'd0, 3'b100, 1'b0}, {2'b10, 2'd1, 3'b100, 1'b0},
    {2'b10, 2'd3, 3'b110, 1'b0}, {2'b11, 2'd2, 3'b110, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic enterMode(input logic [1:0] m);
    cfgWe = 1'b1; cfgModeIn = m; cfgMaskIn = curMask; cfgQualIn = curQual;
    tick();
    cfgWe = 1'b0;
    idleReq = 1'b1;
    tick();
    idleReq = 1'b0;
  endtask

  task automatic recover();
    nmiN = 1'b0;
    for (int k = 0; k < 20 && inLowPower; k++) tick();
    nmiN = 1'b1;
    tick();
  endtask

  task automatic setSrc(input logic [1:0] s, input logic v);
    case (s)
      2'd0: wdIntN = v;
      2'd1: intPendN = v;
      2'd2: nmiN = v;
      default: dbgReqN = v;
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgModeIn = '0; cfgMaskIn = '0; cfgQualIn = '0;
    idleReq = 1'b0; wdIntN = 1'b1; nmiN = 1'b1; intPendN = 1'b1; dbgReqN = 1'b1;
    gpioIn = '1;
    tick(); tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    chk("R1 enables", {29'd0, oscEn, cpuClkEn, sysClkOutEn}, 32'h7);
    chk("R1 lowpower", {31'd0, inLowPower}, 32'd0);
    chk("R1 mode", {30'd0, lpMode}, 32'd0);
    chk("R1 wakepulse", {31'd0, wakePulse}, 32'd0);

    // table: per-mode clocks and wake sources (R2..R8)
    for (int i = 0; i < 12; i++) begin
      logic [1:0] m;
      logic [1:0] s;
      m = VEC[i][7:6];
      s = VEC[i][5:4];
      enterMode(m);
      chk("R2-R5 lowpower", {31'd0, inLowPower}, 32'd1);
      if (m == 2'b00) begin
        chk("R2 clocks", {29'd0, oscEn, cpuClkEn, sysClkOutEn}, 32'h7);
        chk("R2 mode", {30'd0, lpMode}, 32'd0);
      end else if (m == 2'b01) begin
        chk("R3 clocks", {29'd0, oscEn, cpuClkEn, sysClkOutEn}, 32'h4);
        chk("R3 mode", {30'd0, lpMode}, 32'd1);
      end else begin
        chk("R4 clocks", {29'd0, oscEn, cpuClkEn, sysClkOutEn}, 32'h0);
        chk((m == 2'b11) ? "R5 mode" : "R4 mode", {30'd0, lpMode}, 32'd2);
      end
      setSrc(s, 1'b0);
      tick();
      chk((m == 2'b00) ? "R6 wake" : (m == 2'b01) ? "R7 wake" : "R8 wake",
          {29'd0, inLowPower, oscEn, cpuClkEn}, {29'd0, VEC[i][3:1]});
      setSrc(s, 1'b1);
      recover();
    end

    // R1/R9: cleared mask, GPIO low never wakes the middle mode
    enterMode(2'b01);
    gpioIn = '0;
    repeat (10) tick();
    chk("R9 masked gpio", {31'd0, inLowPower}, 32'd1);
    gpioIn = '1;
    recover();

    // R6: GPIO ignored in light mode even when selected
    curMask = 32'h0000_0020; curQual = 6'd3;
    enterMode(2'b00);
    gpioIn = ~32'h20;
    repeat (5) tick();
    chk("R6 gpio ignored", {31'd0, inLowPower}, 32'd1);
    gpioIn = '1;
    recover();

    // R9: unselected line in middle mode
    enterMode(2'b01);
    gpioIn = ~32'h08;
    repeat (10) tick();
    chk("R9 unselected line", {31'd0, inLowPower}, 32'd1);
    // R10: window 4, three lows then high stays asleep
    gpioIn = ~32'h20;
    repeat (3) tick();
    chk("R10 short pulse", {31'd0, inLowPower}, 32'd1);
    gpioIn = '1;
    tick();
    chk("R10 after release", {31'd0, inLowPower}, 32'd1);
    gpioIn = ~32'h20;
    repeat (3) tick();
    chk("R10 edge 3 of 4", {31'd0, inLowPower}, 32'd1);
    tick();
    chk("R10 edge 4 wakes", {31'd0, inLowPower}, 32'd0);
    chk("R12 pulse high", {31'd0, wakePulse}, 32'd1);
    tick();
    chk("R12 pulse low", {31'd0, wakePulse}, 32'd0);
    gpioIn = '1;
    tick();

    // R11: code 0 gives a window of 2
    curQual = 6'd0;
    enterMode(2'b01);
    gpioIn = ~32'h20;
    tick();
    chk("R11 one low edge", {31'd0, inLowPower}, 32'd1);
    gpioIn = '1;
    tick();
    gpioIn = ~32'h20;
    tick(); tick();
    chk("R11 two low edges wake", {31'd0, inLowPower}, 32'd0);
    gpioIn = '1;
    tick();

    // R8: deep-mode GPIO wake with 16-edge stabilisation
    enterMode(2'b10);
    gpioIn = ~32'h20;
    tick();
    gpioIn = '1;
    chk("R8 osc restarted", {29'd0, inLowPower, oscEn, cpuClkEn}, 32'h6);
    repeat (15) tick();
    chk("R8 edge 16 still warm", {29'd0, inLowPower, oscEn, cpuClkEn}, 32'h6);
    tick();
    chk("R8 edge 17 running", {29'd0, inLowPower, oscEn, cpuClkEn}, 32'h3);
    chk("R12 pulse after deep", {31'd0, wakePulse}, 32'd1);
    tick();

    // R13: write while asleep is ignored
    enterMode(2'b01);
    cfgWe = 1'b1; cfgModeIn = 2'b10;
    tick();
    cfgWe = 1'b0;
    recover();
    idleReq = 1'b1;
    tick();
    idleReq = 1'b0;
    chk("R13 mode kept", {30'd0, lpMode}, 32'd1);
    recover();

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule